// File: doc/BRIEF.md
# Banked Scratch RAM with Hardware Stack

This block is the 128-byte internal data store of a small 8-bit controller. One access port reaches any byte in one of four ways. A register number (0 to 7) can be remapped through a 2-bit bank select. A byte address can be given directly. A byte address can be fetched from register 0 or register 1 of the selected bank. A bit address can select a single bit in a 16-byte window. All read results are registered, so they appear one cycle after the request.

Alongside the access port sits an 8-bit stack pointer with its own write and read paths. Pushes pre-increment the pointer and then store. Pops read at the pointer and then decrement it. A 16-bit value travels as two bytes, low byte first. When a stack byte would land above the 128-byte array, that byte is dropped and an error pulse is raised. The pointer itself wraps modulo 256.

Top module: `ctl_scratch_ram`

## Requirements
- R1: After reset, sp_o is 07h, rd_data_o, pop_data_o and stk_err_o are zero, and every byte 00h–7Fh reads 00h.
- R2: With acc_mode_i=1 (direct), acc_addr_i is the byte address. A write stores acc_wdata_i. A read presents the byte on rd_data_o one cycle later and holds it until the next read. Addresses 80h–FFh are ignored on writes and read as 00h.
- R3: With acc_mode_i=0 (register), the byte address is bank_sel_i×8 + acc_addr_i[2:0], for both reads and writes.
- R4: With acc_mode_i=2 (indirect), acc_addr_i[0] picks register 0 or 1 of the selected bank, and that register's contents is the byte address. A pointer of 80h or more makes writes ignored and reads return 00h.
- R5: With acc_mode_i=3 (bit), bit address n = acc_addr_i (below 80h) names byte 20h + n/8, bit n mod 8. A read returns the bit in rd_data_o[0] with the upper bits zero. A write stores acc_wdata_i[0] and changes no other bit of the byte. Bit addresses of 80h and above are ignored on writes and read as 00h.
- R6: A push (push_i) adds one to sp_o and writes push_data_i[7:0] at the new pointer value.
- R7: A narrow pop (pop_i, wide_i=0) presents {00h, byte at sp_o} on pop_data_o one cycle later and lowers sp_o by one.
- R8: With wide_i=1, a push writes push_data_i[7:0] at sp+1 and push_data_i[15:8] at sp+2 and adds two to sp_o. A wide pop returns {byte at sp, byte at sp−1} and subtracts two.
- R9: A stack byte whose address is 80h or more is neither written nor read (it reads as 00h). stk_err_o is high for the one cycle after such a request and low after any other cycle. sp_o wraps modulo 256.
- R10: If a push and an access-port write hit the same byte in one cycle, the push data is stored. If a push and a pop arrive together, only the push takes effect and pop_data_o keeps its value.
- R11: A read in the same cycle as a write to the same byte returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bank_sel_i | input | 2 | Selected register bank |
| acc_en_i | input | 1 | Access port request |
| acc_we_i | input | 1 | Access is a write when 1 |
| acc_mode_i | input | 2 | 0 register, 1 direct, 2 indirect, 3 bit |
| acc_addr_i | input | 8 | Register number, byte address, pointer select or bit address |
| acc_wdata_i | input | 8 | Write byte (bit 0 for bit writes) |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| wide_i | input | 1 | Stack request moves two bytes |
| push_data_i | input | 16 | Push value, low byte in bits 7:0 |
| rd_data_o | output | 8 | Registered access read data |
| pop_data_o | output | 16 | Registered pop data |
| sp_o | output | 8 | Current stack pointer |
| stk_err_o | output | 1 | Out-of-array stack access, one-cycle pulse |

## Verification
Every result of this block is due exactly one clock edge after its request. That covers read data, pop data, the error pulse and the new pointer value. Each stimulus is driven at a falling edge and removed at the next falling edge, and the outputs are sampled at that second falling edge. By then the single rising edge in between has registered the result, and no later request can have disturbed it. Memory effects of writes, pushes and bit updates are confirmed by a separate direct read. Their checks therefore land two falling edges after the write.

// File: rtl/ctl_ram_pkg.sv
package ctl_ram_pkg;
  typedef enum logic [1:0] {
    AM_REG = 2'd0,
    AM_DIR = 2'd1,
    AM_IND = 2'd2,
    AM_BIT = 2'd3
  } acc_mode_e;
endpackage

// File: rtl/ctl_ram_array.sv
module ctl_ram_array #(
  parameter int BYTES = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wa_en_i,
  input  logic [AW-1:0] wa_addr_i,
  input  logic [DW-1:0] wa_data_i,
  input  logic          ws0_en_i,
  input  logic [AW-1:0] ws0_addr_i,
  input  logic [DW-1:0] ws0_data_i,
  input  logic          ws1_en_i,
  input  logic [AW-1:0] ws1_addr_i,
  input  logic [DW-1:0] ws1_data_i,
  input  logic [AW-1:0] ra_addr_i,
  input  logic [AW-1:0] ri_addr_i,
  input  logic [AW-1:0] rs0_addr_i,
  input  logic [AW-1:0] rs1_addr_i,
  output logic [DW-1:0] ra_data_o,
  output logic [DW-1:0] ri_data_o,
  output logic [DW-1:0] rs0_data_o,
  output logic [DW-1:0] rs1_data_o
);
  logic [DW-1:0] mem_q [BYTES];
  logic [DW-1:0] mem_d [BYTES];
  logic          any_we;

  assign any_we = wa_en_i | ws0_en_i | ws1_en_i;

  // stack ports overrule the access port on a shared byte
  always_comb begin
    for (int i = 0; i < BYTES; i++) begin
      mem_d[i] = mem_q[i];
      if (wa_en_i  && wa_addr_i  == AW'(i)) mem_d[i] = wa_data_i;
      if (ws0_en_i && ws0_addr_i == AW'(i)) mem_d[i] = ws0_data_i;
      if (ws1_en_i && ws1_addr_i == AW'(i)) mem_d[i] = ws1_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) mem_q[i] <= '0;
    end else if (any_we) begin
      for (int i = 0; i < BYTES; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign ra_data_o  = mem_q[ra_addr_i];
  assign ri_data_o  = mem_q[ri_addr_i];
  assign rs0_data_o = mem_q[rs0_addr_i];
  assign rs1_data_o = mem_q[rs1_addr_i];
endmodule

// File: rtl/ctl_ram_agen.sv
module ctl_ram_agen
  import ctl_ram_pkg::*;
#(
  parameter int BYTES     = 128,
  parameter int BANKS     = 4,
  parameter int BANK_REGS = 8,
  parameter int BIT_BASE  = 32,
  parameter int BIT_BYTES = 16,
  parameter int DW        = 8,
  localparam int AW  = $clog2(BYTES),
  localparam int BW  = $clog2(BANKS),
  localparam int BPW = $clog2(DW)
) (
  input  acc_mode_e      mode_i,
  input  logic [BW-1:0]  bank_i,
  input  logic [DW-1:0]  acc_addr_i,
  input  logic [DW-1:0]  ptr_data_i,
  output logic [AW-1:0]  ptr_addr_o,
  output logic [AW-1:0]  byte_addr_o,
  output logic           in_range_o,
  output logic           bit_mode_o,
  output logic [BPW-1:0] bit_pos_o
);
  localparam int RW       = $clog2(BANK_REGS);
  localparam int BIT_SPAN = BIT_BYTES * DW;

  logic [DW-1:0] full;
  logic          bit_ok;
  logic          byte_ok;

  assign ptr_addr_o = AW'({bank_i, {(RW-1){1'b0}}, acc_addr_i[0]});

  always_comb begin
    full = '0;
    unique case (mode_i)
      AM_REG:  full = DW'({bank_i, acc_addr_i[RW-1:0]});
      AM_DIR:  full = acc_addr_i;
      AM_IND:  full = ptr_data_i;
      AM_BIT:  full = DW'(BIT_BASE) + (acc_addr_i >> BPW);
      default: full = '0;
    endcase
  end

  assign bit_ok      = {1'b0, acc_addr_i} < (DW+1)'(BIT_SPAN);
  assign byte_ok     = {1'b0, full} < (DW+1)'(BYTES);
  assign bit_mode_o  = (mode_i == AM_BIT);
  assign in_range_o  = bit_mode_o ? bit_ok : byte_ok;
  assign byte_addr_o = full[AW-1:0];
  assign bit_pos_o   = acc_addr_i[BPW-1:0];
endmodule

// File: rtl/ctl_ram_stack.sv
module ctl_ram_stack #(
  parameter int BYTES   = 128,
  parameter int DW      = 8,
  parameter int SP_INIT = 7,
  localparam int AW     = $clog2(BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic            wide_i,
  input  logic [2*DW-1:0] push_data_i,
  input  logic [DW-1:0]   rd_top_i,
  input  logic [DW-1:0]   rd_next_i,
  output logic [AW-1:0]   top_addr_o,
  output logic [AW-1:0]   next_addr_o,
  output logic            ws0_en_o,
  output logic [AW-1:0]   ws0_addr_o,
  output logic [DW-1:0]   ws0_data_o,
  output logic            ws1_en_o,
  output logic [AW-1:0]   ws1_addr_o,
  output logic [DW-1:0]   ws1_data_o,
  output logic [DW-1:0]   sp_o,
  output logic [2*DW-1:0] pop_data_o,
  output logic            err_o
);
  logic [DW-1:0]   sp_q, sp_d, up1, up2, dn1;
  logic            ok_up1, ok_up2, ok_top, ok_dn1;
  logic            pop_act, sp_en;
  logic [DW-1:0]   top_val, next_val;
  logic [2*DW-1:0] pop_q, pop_d;
  logic            err_q, err_d;

  function automatic logic fits(input logic [DW-1:0] a);
    return {1'b0, a} < (DW+1)'(BYTES);
  endfunction

  assign up1     = sp_q + DW'(1);
  assign up2     = sp_q + DW'(2);
  assign dn1     = sp_q - DW'(1);
  assign ok_up1  = fits(up1);
  assign ok_up2  = fits(up2);
  assign ok_top  = fits(sp_q);
  assign ok_dn1  = fits(dn1);
  assign pop_act = pop_i & ~push_i;
  assign sp_en   = push_i | pop_i;

  assign ws0_en_o   = push_i & ok_up1;
  assign ws0_addr_o = up1[AW-1:0];
  assign ws0_data_o = push_data_i[DW-1:0];
  assign ws1_en_o   = push_i & wide_i & ok_up2;
  assign ws1_addr_o = up2[AW-1:0];
  assign ws1_data_o = push_data_i[2*DW-1:DW];

  assign top_addr_o  = sp_q[AW-1:0];
  assign next_addr_o = dn1[AW-1:0];
  assign top_val     = ok_top ? rd_top_i  : '0;
  assign next_val    = ok_dn1 ? rd_next_i : '0;

  always_comb begin
    sp_d  = sp_q;
    err_d = 1'b0;
    pop_d = wide_i ? {top_val, next_val} : {{DW{1'b0}}, top_val};
    if (push_i) begin
      sp_d  = wide_i ? up2 : up1;
      err_d = ~ok_up1 | (wide_i & ~ok_up2);
    end else if (pop_act) begin
      sp_d  = wide_i ? (sp_q - DW'(2)) : dn1;
      err_d = ~ok_top | (wide_i & ~ok_dn1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= DW'(SP_INIT);
    else if (sp_en) sp_q <= sp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pop_q <= '0;
    else if (pop_act) pop_q <= pop_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign sp_o       = sp_q;
  assign pop_data_o = pop_q;
  assign err_o      = err_q;
endmodule

// File: rtl/ctl_scratch_ram.sv
module ctl_scratch_ram
  import ctl_ram_pkg::*;
#(
  parameter int BYTES     = 128,
  parameter int BANKS     = 4,
  parameter int BANK_REGS = 8,
  parameter int BIT_BASE  = 32,
  parameter int BIT_BYTES = 16,
  parameter int DW        = 8,
  parameter int SP_INIT   = 7,
  localparam int BW = $clog2(BANKS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BW-1:0]   bank_sel_i,
  input  logic            acc_en_i,
  input  logic            acc_we_i,
  input  logic [1:0]      acc_mode_i,
  input  logic [DW-1:0]   acc_addr_i,
  input  logic [DW-1:0]   acc_wdata_i,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic            wide_i,
  input  logic [2*DW-1:0] push_data_i,
  output logic [DW-1:0]   rd_data_o,
  output logic [2*DW-1:0] pop_data_o,
  output logic [DW-1:0]   sp_o,
  output logic            stk_err_o
);
  localparam int AW  = $clog2(BYTES);
  localparam int BPW = $clog2(DW);

  logic rst_meta, rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_n_sync, rst_meta} <= 2'b00;
    else        {rst_n_sync, rst_meta} <= {rst_meta, 1'b1};
  end

  logic [AW-1:0]  ptr_addr, byte_addr, top_addr, next_addr;
  logic [AW-1:0]  ws0_addr, ws1_addr;
  logic [DW-1:0]  ptr_data, acc_byte, top_byte, next_byte;
  logic [DW-1:0]  ws0_data, ws1_data, wr_byte, rd_d, rd_q;
  logic           in_range, bit_mode, ws0_en, ws1_en, wa_en, rd_en;
  logic [BPW-1:0] bit_pos;

  ctl_ram_agen #(
    .BYTES(BYTES), .BANKS(BANKS), .BANK_REGS(BANK_REGS),
    .BIT_BASE(BIT_BASE), .BIT_BYTES(BIT_BYTES), .DW(DW)
  ) u_agen (
    .mode_i      (acc_mode_e'(acc_mode_i)),
    .bank_i      (bank_sel_i),
    .acc_addr_i  (acc_addr_i),
    .ptr_data_i  (ptr_data),
    .ptr_addr_o  (ptr_addr),
    .byte_addr_o (byte_addr),
    .in_range_o  (in_range),
    .bit_mode_o  (bit_mode),
    .bit_pos_o   (bit_pos)
  );

  ctl_ram_stack #(.BYTES(BYTES), .DW(DW), .SP_INIT(SP_INIT)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .wide_i      (wide_i),
    .push_data_i (push_data_i),
    .rd_top_i    (top_byte),
    .rd_next_i   (next_byte),
    .top_addr_o  (top_addr),
    .next_addr_o (next_addr),
    .ws0_en_o    (ws0_en),
    .ws0_addr_o  (ws0_addr),
    .ws0_data_o  (ws0_data),
    .ws1_en_o    (ws1_en),
    .ws1_addr_o  (ws1_addr),
    .ws1_data_o  (ws1_data),
    .sp_o        (sp_o),
    .pop_data_o  (pop_data_o),
    .err_o       (stk_err_o)
  );

  ctl_ram_array #(.BYTES(BYTES), .DW(DW)) u_array (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .wa_en_i    (wa_en),
    .wa_addr_i  (byte_addr),
    .wa_data_i  (wr_byte),
    .ws0_en_i   (ws0_en),
    .ws0_addr_i (ws0_addr),
    .ws0_data_i (ws0_data),
    .ws1_en_i   (ws1_en),
    .ws1_addr_i (ws1_addr),
    .ws1_data_i (ws1_data),
    .ra_addr_i  (byte_addr),
    .ri_addr_i  (ptr_addr),
    .rs0_addr_i (top_addr),
    .rs1_addr_i (next_addr),
    .ra_data_o  (acc_byte),
    .ri_data_o  (ptr_data),
    .rs0_data_o (top_byte),
    .rs1_data_o (next_byte)
  );

  // bit writes merge into the byte currently held
  always_comb begin
    wr_byte = acc_wdata_i;
    if (bit_mode) begin
      wr_byte          = acc_byte;
      wr_byte[bit_pos] = acc_wdata_i[0];
    end
  end

  assign wa_en = acc_en_i & acc_we_i & in_range;
  assign rd_en = acc_en_i & ~acc_we_i;

  always_comb begin
    rd_d = '0;
    if (in_range) rd_d = bit_mode ? DW'(acc_byte[bit_pos]) : acc_byte;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) rd_q <= '0;
    else if (rd_en)  rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/ctl_scratch_ram_chk.sv
module ctl_scratch_ram_chk #(
  parameter int BYTES = 128,
  parameter int DW    = 8
) (
  input logic          clk,
  input logic          rst_ns,
  input logic          push_i,
  input logic          pop_i,
  input logic          wide_i,
  input logic [DW-1:0] sp_o,
  input logic          stk_err_o
);
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_ns)
    push_i |=> sp_o == DW'($past(sp_o) + ($past(wide_i) ? DW'(2) : DW'(1)))); // R6

  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_ns)
    (pop_i && !push_i) |=> sp_o == DW'($past(sp_o) - ($past(wide_i) ? DW'(2) : DW'(1)))); // R7

  AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    (!push_i && !pop_i) |=> $stable(sp_o)); // R9

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_ns)
    stk_err_o |-> $past(push_i || pop_i)); // R9

  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_ns)
    (push_i && sp_o >= DW'(BYTES-1) && sp_o != {DW{1'b1}}) |=> stk_err_o); // R9
endmodule

bind ctl_scratch_ram ctl_scratch_ram_chk #(.BYTES(BYTES), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_ns    (rst_n_sync),
  .push_i    (push_i),
  .pop_i     (pop_i),
  .wide_i    (wide_i),
  .sp_o      (sp_o),
  .stk_err_o (stk_err_o)
);

// File: tb/ctl_scratch_ram_bench.sv
module ctl_scratch_ram_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bank_sel;
  logic        acc_en, acc_we;
  logic [1:0]  acc_mode;
  logic [7:0]  acc_addr, acc_wdata;
  logic        push, pop, wide;
  logic [15:0] push_data;
  logic [7:0]  rd_data, sp;
  logic [15:0] pop_data;
  logic        err;

  int vec = 0;
  int fail = 0;
  logic [7:0] m [128];
  logic [7:0] sp_m;

  localparam logic [1:0] MREG = 2'd0, MDIR = 2'd1, MIND = 2'd2, MBIT = 2'd3;

  always #5 clk = ~clk;

  ctl_scratch_ram u_ctl_scratch_ram (
    .clk(clk), .rst_n(rst_n), .bank_sel_i(bank_sel),
    .acc_en_i(acc_en), .acc_we_i(acc_we), .acc_mode_i(acc_mode),
    .acc_addr_i(acc_addr), .acc_wdata_i(acc_wdata),
    .push_i(push), .pop_i(pop), .wide_i(wide), .push_data_i(push_data),
    .rd_data_o(rd_data), .pop_data_o(pop_data), .sp_o(sp), .stk_err_o(err)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vec++;
    if (act !== exp) begin
      fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic we, input logic [1:0] md,
                       input logic [7:0] ad, input logic [7:0] wd,
                       input logic ps, input logic pp, input logic w, input logic [15:0] pd);
    @(negedge clk);
    acc_en = en; acc_we = we; acc_mode = md; acc_addr = ad; acc_wdata = wd;
    push = ps; pop = pp; wide = w; push_data = pd;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0; push = 1'b0; pop = 1'b0; wide = 1'b0;
  endtask

  task automatic wr(input logic [1:0] md, input logic [7:0] ad, input logic [7:0] wd);
    drive(1'b1, 1'b1, md, ad, wd, 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic rd(input logic [1:0] md, input logic [7:0] ad, output logic [7:0] q);
    drive(1'b1, 1'b0, md, ad, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0);
    q = rd_data;
  endtask

  task automatic spush(input logic [15:0] d, input logic w, input string req);
    logic [7:0] a1, a2;
    logic e;
    a1 = sp_m + 8'd1;
    a2 = sp_m + 8'd2;
    e  = a1[7] | (w & a2[7]);
    if (!a1[7]) m[a1[6:0]] = d[7:0];
    if (w && !a2[7]) m[a2[6:0]] = d[15:8];
    sp_m = sp_m + (w ? 8'd2 : 8'd1);
    drive(1'b0, 1'b0, MDIR, 8'h00, 8'h00, 1'b1, 1'b0, w, d);
    check(req, {8'h0, sp}, {8'h0, sp_m});
    check(req, {15'h0, err}, {15'h0, e});
  endtask

  task automatic spop(input logic w, input string req);
    logic [7:0] p0, p1, v0, v1;
    logic e;
    p0 = sp_m;
    p1 = sp_m - 8'd1;
    v0 = p0[7] ? 8'h00 : m[p0[6:0]];
    v1 = p1[7] ? 8'h00 : m[p1[6:0]];
    e  = p0[7] | (w & p1[7]);
    sp_m = sp_m - (w ? 8'd2 : 8'd1);
    drive(1'b0, 1'b0, MDIR, 8'h00, 8'h00, 1'b0, 1'b1, w, 16'h0);
    check(req, pop_data, w ? {v0, v1} : {8'h00, v0});
    check(req, {8'h0, sp}, {8'h0, sp_m});
    check(req, {15'h0, err}, {15'h0, e});
  endtask

  initial begin
    #(200000 * 10);
    fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vec, fail);
    $finish;
  end

  initial begin
    logic [7:0] q, t, byte_a, old;
    rst_n = 1'b0; bank_sel = 2'd0; acc_en = 1'b0; acc_we = 1'b0; acc_mode = MDIR;
    acc_addr = 8'h0; acc_wdata = 8'h0; push = 1'b0; pop = 1'b0; wide = 1'b0; push_data = 16'h0;
    for (int i = 0; i < 128; i++) m[i] = 8'h00;
    sp_m = 8'h07;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1", {8'h0, sp}, 16'h0007);
    check("R1", {8'h0, rd_data}, 16'h0);
    check("R1", pop_data, 16'h0);
    check("R1", {15'h0, err}, 16'h0);
    for (int a = 0; a < 128; a++) begin
      rd(MDIR, 8'(a), q);
      check("R1", {8'h0, q}, 16'h0);
    end

    // R2 direct sweep
    for (int a = 0; a < 128; a++) begin
      t = 8'(a * 37 + 5);
      m[a] = t;
      wr(MDIR, 8'(a), t);
    end
    for (int a = 0; a < 128; a++) begin
      rd(MDIR, 8'(a), q);
      check("R2", {8'h0, q}, {8'h0, m[a]});
    end
    for (int a = 128; a < 132; a++) begin
      wr(MDIR, 8'(a), 8'hFF);
      rd(MDIR, 8'(a), q);
      check("R2", {8'h0, q}, 16'h0);
    end
    rd(MDIR, 8'h00, q);
    check("R2", {8'h0, q}, {8'h0, m[0]});

    // R3 register mode through every bank
    for (int b = 0; b < 4; b++) begin
      bank_sel = 2'(b);
      for (int r = 0; r < 8; r++) begin
        t = 8'(b * 8 + r) ^ 8'hA5;
        m[b*8+r] = t;
        wr(MREG, 8'(r), t);
      end
      for (int r = 0; r < 8; r++) begin
        rd(MDIR, 8'(b * 8 + r), q);
        check("R3", {8'h0, q}, {8'h0, m[b*8+r]});
        rd(MREG, 8'(r), q);
        check("R3", {8'h0, q}, {8'h0, m[b*8+r]});
      end
    end

    // R4 indirect through register 0 and 1 of each bank
    for (int b = 0; b < 4; b++) begin
      bank_sel = 2'(b);
      for (int s = 0; s < 2; s++) begin
        t = 8'(8'h30 + b * 4 + s);
        m[b*8+s] = t;
        wr(MDIR, 8'(b * 8 + s), t);
        m[t[6:0]] = t ^ 8'h5A;
        wr(MIND, 8'(s), t ^ 8'h5A);
        rd(MDIR, t, q);
        check("R4", {8'h0, q}, {8'h0, m[t[6:0]]});
        rd(MIND, 8'(s), q);
        check("R4", {8'h0, q}, {8'h0, m[t[6:0]]});
      end
    end
    bank_sel = 2'd1;
    m[8] = 8'h90;
    wr(MDIR, 8'h08, 8'h90);
    wr(MIND, 8'h00, 8'h3C);
    rd(MIND, 8'h00, q);
    check("R4", {8'h0, q}, 16'h0);
    bank_sel = 2'd0;

    // R5 bit sweep: set then clear every bit
    for (int n = 0; n < 128; n++) begin
      byte_a = 8'(8'h20 + n / 8);
      for (int v = 1; v >= 0; v--) begin
        m[byte_a[6:0]][n % 8] = 1'(v);
        wr(MBIT, 8'(n), 8'(v));
        rd(MBIT, 8'(n), q);
        check("R5", {8'h0, q}, 16'(v));
        rd(MDIR, byte_a, q);
        check("R5", {8'h0, q}, {8'h0, m[byte_a[6:0]]});
      end
    end
    wr(MBIT, 8'h85, 8'h01);
    rd(MBIT, 8'h85, q);
    check("R5", {8'h0, q}, 16'h0);

    // R6 / R7 narrow stack
    for (int i = 0; i < 5; i++) spush(16'(8'hC0 + i), 1'b0, "R6");
    for (int i = 0; i < 5; i++) begin
      rd(MDIR, 8'(8 + i), q);
      check("R6", {8'h0, q}, {8'h0, m[8+i]});
    end
    for (int i = 0; i < 5; i++) spop(1'b0, "R7");

    // R8 wide stack
    spush(16'hBEEF, 1'b1, "R8");
    rd(MDIR, 8'h08, q);
    check("R8", {8'h0, q}, 16'h00EF);
    rd(MDIR, 8'h09, q);
    check("R8", {8'h0, q}, 16'h00BE);
    spop(1'b1, "R8");

    // R9 overflow, error, wrap
    for (int i = 0; i < 120; i++) spush(16'(i), 1'b0, "R9");
    check("R9", {8'h0, sp}, 16'h007F);
    spush(16'h00CC, 1'b0, "R9");
    spop(1'b0, "R9");
    spush(16'h00CC, 1'b0, "R9");
    spush(16'hAAAA, 1'b1, "R9");
    for (int i = 0; i < 125; i++) spush(16'h00DD, 1'b0, "R9");
    check("R9", {8'h0, sp}, 16'h00FF);
    spush(16'h0077, 1'b0, "R9");
    rd(MDIR, 8'h00, q);
    check("R9", {8'h0, q}, 16'h0077);
    spop(1'b0, "R9");

    // R10 push wins against an access write to the same byte
    m[0] = 8'h11;
    sp_m = 8'h00;
    drive(1'b1, 1'b1, MDIR, 8'h00, 8'h99, 1'b1, 1'b0, 1'b0, 16'h0011);
    check("R10", {8'h0, sp}, 16'h0000);
    rd(MDIR, 8'h00, q);
    check("R10", {8'h0, q}, 16'h0011);
    // R10 push together with pop: only the push acts
    m[1] = 8'h22;
    sp_m = 8'h01;
    drive(1'b0, 1'b0, MDIR, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 16'h0022);
    check("R10", {8'h0, sp}, 16'h0001);
    check("R10", pop_data, 16'h0077);
    rd(MDIR, 8'h01, q);
    check("R10", {8'h0, q}, 16'h0022);

    // R11 read sees the byte before a same-cycle push write
    old = m[2];
    drive(1'b1, 1'b0, MDIR, 8'h02, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0033);
    check("R11", {8'h0, rd_data}, {8'h0, old});
    m[2] = 8'h33;
    rd(MDIR, 8'h02, q);
    check("R11", {8'h0, q}, 16'h0033);

    $display("== %0d vectors applied, %0d miscompares ==", vec, fail);
    $finish;
  end
endmodule